// File: doc/BRIEF.md
# Keyed Multi-Channel Watchdog Timer

This block is a watchdog timer for a low-power system. It sits on a simple memory-mapped register bus and counts down on a slow tick enable, nominally 32768 Hz. A timeout of T milliseconds therefore needs a reload value of T*32768/1000 ticks. Before starting the watchdog, software programs four things: the reload value, which kick channels are armed, and whether counting continues while the CPU sleeps or is held by a debugger. It then issues a start command. After that, nothing on the bus can stop the watchdog.

The counter is refreshed only when every armed kick channel has been written with a fixed 32-bit key word since the last refresh. Separate software tasks can each own a channel, so the system stays alive only while all of them make progress. When the count runs out, the block sets a sticky expiry flag and raises an interrupt if that is enabled. Two ticks later it issues a one-cycle reset request to the system reset controller.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is idle, and every register reads back as follows: run status 0, expiry flag 0, interrupt enable 0, reload value 0xFFFFFFFF, armed-channel mask 0x01, mode 0. Both `irq` and `rst_req` are low.
- R2: Writing a word with bit 0 set to the command register (0x00) starts the watchdog. The count register (0x24) then holds the reload value and drops by one on each tick where counting is not paused.
- R3: A reload value of 0 is loaded as 1, so the count register never reads 0 while the watchdog runs.
- R4: A tick that takes the count from 1 sets the expiry flag (0x04, bit 0) and reloads the counter from the reload value, unless a kick completes in the same cycle.
- R5: The interrupt enable reads at bit 0 of both 0x08 and 0x0C. Writing 1 to bit 0 of 0x08 sets it, and writing 1 to bit 0 of 0x0C clears it. `irq` is high exactly when the expiry flag and the enable are both set.
- R6: `rst_req` pulses high for one clock, in the cycle of the second tick after the tick that expired the counter.
- R7: Kick channel n is written at 0x40+4n. A write counts only when it carries the key 0x6E524635 and channel n is armed. Any other word, or a write to an unarmed channel, leaves the pending mask (0x14) unchanged.
- R8: The pending mask holds one bit per armed channel that is still awaited. When the last awaited channel receives the key, the counter reloads and the pending mask is re-armed with the armed-channel mask (0x1C).
- R9: While the watchdog runs, writes to the reload value (0x18), the armed-channel mask (0x1C) and the mode register (0x20) are ignored. Running can never be cleared by any write.
- R10: Mode bit 0 set lets counting continue while `cpu_sleep` is high, and mode bit 1 does the same for `cpu_halt`. When the matching bit is clear, ticks are ignored while that input is high.
- R11: Writing a word with bit 0 clear to 0x04 clears the expiry flag. Writing bit 0 set does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-clock tick of the slow count clock |
| cpu_sleep | input | 1 | CPU is in a sleep state |
| cpu_halt | input | 1 | CPU is held by a debugger |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count or a lost reload shows up at `irq` and `rst_req` on the wrong tick, never later than the programmed reload plus two ticks. The count register exposes the same error on the very next tick. A pending mask that has drifted from the armed channels either refreshes the counter too early or blocks the refresh altogether. Either fault can be seen in the count register right after the last key write, without waiting for a timeout. A pause decode that is wrong shows up as a count that changes, or does not change, on a single tick taken while sleeping or halted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // Per-state run permission: 1 keeps counting, 0 pauses.
  typedef struct packed {
    logic run_halt;   // mode bit 1
    logic run_sleep;  // mode bit 0
  } wdt_mode_t;

  // Register byte offsets.
  localparam logic [7:0] OFS_CMD     = 8'h00;
  localparam logic [7:0] OFS_EXPIRED = 8'h04;
  localparam logic [7:0] OFS_IEN_SET = 8'h08;
  localparam logic [7:0] OFS_IEN_CLR = 8'h0C;
  localparam logic [7:0] OFS_RUN     = 8'h10;
  localparam logic [7:0] OFS_PEND    = 8'h14;
  localparam logic [7:0] OFS_RELOAD  = 8'h18;
  localparam logic [7:0] OFS_CHAN_EN = 8'h1C;
  localparam logic [7:0] OFS_MODE    = 8'h20;
  localparam logic [7:0] OFS_COUNT   = 8'h24;
  localparam logic [7:0] OFS_KICK0   = 8'h40;

  // A zero reload would time out at once or wrap, so it is raised to 1.
  function automatic word_t reload_floor(input word_t v);
    return (v == '0) ? word_t'(1) : v;
  endfunction

  function automatic logic key_ok(input word_t v, input word_t key);
    return v == key;
  endfunction

  function automatic logic pause_now(input wdt_mode_t m, input logic sleep,
                                     input logic halt);
    return (sleep & ~m.run_sleep) | (halt & ~m.run_halt);
  endfunction

  function automatic logic [7:0] kick_addr(input int unsigned ch);
    return OFS_KICK0 + 8'(ch * 4);
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter logic [31:0] RESET_RELOAD = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  output word_t             bus_rdata,
  input  logic              running,
  input  word_t             count,
  input  logic [NUM_CH-1:0] pending,
  input  logic              expired,
  output logic              start_pulse,
  output logic              clr_expired,
  output word_t             reload_val,
  output logic [NUM_CH-1:0] chan_en,
  output wdt_mode_t         mode,
  output logic              irq_en,
  output logic [NUM_CH-1:0] kick_wr
);

  logic [7:0] a8;
  assign a8 = 8'(bus_addr);

  logic cfg_open;
  assign cfg_open = bus_wr & ~running;

  assign start_pulse = bus_wr & (a8 == OFS_CMD) & bus_wdata[0];
  assign clr_expired = bus_wr & (a8 == OFS_EXPIRED) & ~bus_wdata[0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_kick_dec
    assign kick_wr[n] = bus_wr & (a8 == kick_addr(n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= RESET_RELOAD;
      chan_en    <= NUM_CH'(1);
      mode       <= '0;
      irq_en     <= 1'b0;
    end else begin
      if (cfg_open && a8 == OFS_RELOAD)  reload_val <= bus_wdata;
      if (cfg_open && a8 == OFS_CHAN_EN) chan_en    <= bus_wdata[NUM_CH-1:0];
      if (cfg_open && a8 == OFS_MODE)    mode       <= bus_wdata[1:0];
      if (bus_wr && a8 == OFS_IEN_SET && bus_wdata[0]) irq_en <= 1'b1;
      else if (bus_wr && a8 == OFS_IEN_CLR && bus_wdata[0]) irq_en <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (a8)
      OFS_EXPIRED: bus_rdata[0] = expired;
      OFS_IEN_SET: bus_rdata[0] = irq_en;
      OFS_IEN_CLR: bus_rdata[0] = irq_en;
      OFS_RUN:     bus_rdata[0] = running;
      OFS_PEND:    bus_rdata[NUM_CH-1:0] = pending;
      OFS_RELOAD:  bus_rdata = reload_val;
      OFS_CHAN_EN: bus_rdata[NUM_CH-1:0] = chan_en;
      OFS_MODE:    bus_rdata[1:0] = mode;
      OFS_COUNT:   bus_rdata = count;
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_kick.sv
module wdt_kick
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter logic [31:0] KEY    = 32'h6E52_4635
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] kick_wr,
  input  word_t             wdata,
  output logic [NUM_CH-1:0] pending,
  output logic              kick_done
);

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] remaining;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    assign hit[n] = kick_wr[n] & chan_en[n] & key_ok(wdata, KEY);
  end

  assign remaining = pending & ~hit;
  assign kick_done = running & (|(hit & pending)) & (remaining == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pending <= NUM_CH'(1);
    else if (!running)   pending <= chan_en;
    else if (kick_done)  pending <= chan_en;
    else                 pending <= remaining;
  end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned RST_DELAY = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      cpu_sleep,
  input  logic      cpu_halt,
  input  logic      start_pulse,
  input  logic      kick_done,
  input  logic      clr_expired,
  input  word_t     reload_val,
  input  wdt_mode_t mode,
  output logic      running,
  output word_t     count,
  output logic      expired,
  output logic      expire_evt,
  output logic      paused,
  output logic      rst_req
);

  localparam int unsigned DLY_W = $clog2(RST_DELAY + 1);

  word_t            load_val;
  logic             step;
  logic             armed;
  logic [DLY_W-1:0] dly;

  assign load_val   = reload_floor(reload_val);
  assign paused     = pause_now(mode, cpu_sleep, cpu_halt);
  assign step       = running & tick_en & ~paused;
  assign expire_evt = step & ~kick_done & (count == word_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else begin
      if (start_pulse) running <= 1'b1;
      if (start_pulse && !running) count <= load_val;
      else if (running && (kick_done || expire_evt)) count <= load_val;
      else if (step) count <= count - word_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           expired <= 1'b0;
    else if (expire_evt)  expired <= 1'b1;
    else if (clr_expired) expired <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      dly     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= armed & tick_en & (dly == DLY_W'(1));
      if (expire_evt) begin
        armed <= 1'b1;
        dly   <= DLY_W'(RST_DELAY);
      end else if (armed && tick_en) begin
        if (dly == DLY_W'(1)) armed <= 1'b0;
        dly <= dly - DLY_W'(1);
      end
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned RST_DELAY    = 2,
  parameter logic [31:0] KEY          = 32'h6E52_4635,
  parameter logic [31:0] RESET_RELOAD = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cpu_sleep,
  input  logic              cpu_halt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);

  logic              start_pulse;
  logic              clr_expired;
  word_t             reload_val;
  logic [NUM_CH-1:0] chan_en;
  wdt_mode_t         mode;
  logic              irq_en;
  logic [NUM_CH-1:0] kick_wr;
  logic [NUM_CH-1:0] pending;
  logic              kick_done;
  logic              running;
  word_t             count;
  logic              expired;
  logic              expire_evt;
  logic              paused;

  wdt_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .RESET_RELOAD(RESET_RELOAD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .running(running),
    .count(count), .pending(pending), .expired(expired),
    .start_pulse(start_pulse), .clr_expired(clr_expired),
    .reload_val(reload_val), .chan_en(chan_en), .mode(mode),
    .irq_en(irq_en), .kick_wr(kick_wr)
  );

  wdt_kick #(.NUM_CH(NUM_CH), .KEY(KEY)) u_kick (
    .clk(clk), .rst_n(rst_n), .running(running), .chan_en(chan_en),
    .kick_wr(kick_wr), .wdata(bus_wdata), .pending(pending),
    .kick_done(kick_done)
  );

  wdt_core #(.RST_DELAY(RST_DELAY)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_sleep(cpu_sleep),
    .cpu_halt(cpu_halt), .start_pulse(start_pulse), .kick_done(kick_done),
    .clr_expired(clr_expired), .reload_val(reload_val), .mode(mode),
    .running(running), .count(count), .expired(expired),
    .expire_evt(expire_evt), .paused(paused), .rst_req(rst_req)
  );

  assign irq = expired & irq_en;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              running,
  input logic [31:0]       count,
  input logic [31:0]       reload_val,
  input logic [NUM_CH-1:0] pending,
  input logic [NUM_CH-1:0] chan_en,
  input logic              kick_done,
  input logic              expire_evt,
  input logic              expired,
  input logic              paused,
  input logic              rst_req
);

  p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> count != 32'd0);

  p_kick_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && kick_done) |=>
      count == (($past(reload_val) == 32'd0) ? 32'd1 : $past(reload_val)));

  p_pending_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pending & ~chan_en) == '0);

  p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && paused && !kick_done) |=> $stable(count));

  p_expire_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> expired);

  p_rst_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick_en));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!expired && !rst_req));

endmodule

bind keyed_watchdog wdt_checker #(.NUM_CH(NUM_CH)) i_wdt_checker (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .running(running),
  .count(count), .reload_val(reload_val), .pending(pending),
  .chan_en(chan_en), .kick_done(kick_done), .expire_evt(expire_evt),
  .expired(expired), .paused(paused), .rst_req(rst_req)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

  localparam logic [7:0] A_CMD = 8'h00, A_EXP = 8'h04, A_ISET = 8'h08,
                         A_ICLR = 8'h0C, A_RUN = 8'h10, A_PEND = 8'h14,
                         A_REL = 8'h18, A_CHEN = 8'h1C, A_MODE = 8'h20,
                         A_CNT = 8'h24, A_K0 = 8'h40;
  localparam logic [31:0] GOOD_KEY = 32'h6E52_4635;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cpu_sleep = 1'b0;
  logic        cpu_halt = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_sleep(cpu_sleep),
    .cpu_halt(cpu_halt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; cpu_sleep = 1'b0; cpu_halt = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a,
                            input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_reg("R1 run", A_RUN, 0);
    expect_reg("R1 expired", A_EXP, 0);
    expect_reg("R1 ien", A_ISET, 0);
    expect_reg("R1 reload", A_REL, 32'hFFFF_FFFF);
    expect_reg("R1 chan_en", A_CHEN, 32'h1);
    expect_reg("R1 mode", A_MODE, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst_req", {31'b0, rst_req}, 0);
  endtask

  task automatic t_kicks();
    do_reset();
    wr(A_REL, 5);
    wr(A_CHEN, 32'h05);
    wr(A_CMD, 1);
    expect_reg("R2 running", A_RUN, 1);
    expect_reg("R2 loaded", A_CNT, 5);
    expect_reg("R8 pending armed", A_PEND, 32'h05);
    tick();
    expect_reg("R2 decrement", A_CNT, 4);
    wr(A_K0, 32'h1234_5678);
    expect_reg("R7 wrong key", A_PEND, 32'h05);
    wr(A_K0 + 8'd4, GOOD_KEY);
    expect_reg("R7 unarmed channel", A_PEND, 32'h05);
    wr(A_K0, GOOD_KEY);
    expect_reg("R7 ch0 cleared", A_PEND, 32'h04);
    expect_reg("R8 no early reload", A_CNT, 4);
    wr(A_K0 + 8'd8, GOOD_KEY);
    expect_reg("R8 reload", A_CNT, 5);
    expect_reg("R8 re-armed", A_PEND, 32'h05);
    wr(A_REL, 9);
    expect_reg("R9 reload locked", A_REL, 5);
    wr(A_CHEN, 32'hFF);
    expect_reg("R9 chan_en locked", A_CHEN, 32'h05);
    wr(A_MODE, 3);
    expect_reg("R9 mode locked", A_MODE, 0);
    wr(A_CMD, 0);
    expect_reg("R9 cannot stop", A_RUN, 1);
  endtask

  task automatic t_expiry();
    do_reset();
    wr(A_REL, 3);
    wr(A_ISET, 1);
    wr(A_CMD, 1);
    tick(); tick();
    expect_reg("R4 not yet", A_EXP, 0);
    tick();
    expect_reg("R4 expired", A_EXP, 1);
    check("R5 irq high", {31'b0, irq}, 1);
    expect_reg("R4 reloaded", A_CNT, 3);
    check("R6 not at expiry", {31'b0, rst_req}, 0);
    tick();
    check("R6 not first tick", {31'b0, rst_req}, 0);
    tick();
    check("R6 pulse", {31'b0, rst_req}, 1);
    @(negedge clk);
    check("R6 one cycle", {31'b0, rst_req}, 0);
    wr(A_ICLR, 1);
    expect_reg("R5 enable cleared", A_ICLR, 0);
    check("R5 irq masked", {31'b0, irq}, 0);
    wr(A_EXP, 0);
    expect_reg("R11 cleared", A_EXP, 0);
    wr(A_EXP, 1);
    expect_reg("R11 no set", A_EXP, 0);
  endtask

  task automatic t_zero_reload();
    do_reset();
    wr(A_REL, 0);
    wr(A_CMD, 1);
    expect_reg("R3 floor", A_CNT, 1);
    tick();
    expect_reg("R3 expiry", A_EXP, 1);
    expect_reg("R3 reload", A_CNT, 1);
  endtask

  task automatic t_pause();
    do_reset();
    wr(A_REL, 10);
    wr(A_CMD, 1);
    cpu_sleep = 1'b1;
    tick();
    expect_reg("R10 sleep pauses", A_CNT, 10);
    cpu_sleep = 1'b0;
    tick();
    expect_reg("R10 awake counts", A_CNT, 9);
    do_reset();
    wr(A_REL, 10);
    wr(A_MODE, 1);
    wr(A_CMD, 1);
    cpu_sleep = 1'b1;
    tick();
    expect_reg("R10 sleep runs", A_CNT, 9);
    cpu_sleep = 1'b0;
    cpu_halt = 1'b1;
    tick();
    expect_reg("R10 halt pauses", A_CNT, 9);
    cpu_halt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_kicks();
    t_expiry();
    t_zero_reload();
    t_pause();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule